// File: doc/BRIEF.md
# Accumulator Execution Unit with Skip and Branch Sequencing

This block is the execution core of a small 8-bit accumulator machine. Each cycle it can take one already-decoded instruction and apply it to a 128-entry data register bank, a working register (W) and a zero flag (Z). It also keeps a 13-bit program counter. The supported operations are register increment, two conditional-skip counters (increment and decrement), OR of W with a register, OR of W with an immediate byte, and an unconditional jump.

A skip instruction whose 8-bit result is zero turns the following slot into a bubble. A jump always costs a bubble slot. During a bubble `busy_o` is high and whatever is offered on the instruction port is dropped. A jump builds its target from an 11-bit immediate plus two bits taken from a separate page latch, which has its own write port.

Top module: `acc_skip_core`

## Requirements
- R1: The instruction fields are `ins_op` (0 increment, 1 decrement-skip, 2 increment-skip, 3 OR with register, 4 OR with immediate, 5 jump, 6 and 7 no operation), `ins_addr` (register index 0..127) and `ins_dst` (0 writes the result to W, 1 writes it to the indexed register). A no-operation code changes nothing except advancing the PC by one.
- R2: Increment writes (f+1) mod 256 to the selected destination and sets Z when the result is zero, clearing Z otherwise.
- R3: OR with register writes W|f to the selected destination and updates Z from the result.
- R4: OR with immediate writes W|`ins_lit[7:0]` to W, whatever `ins_dst` is, and updates Z.
- R5: Decrement-skip and increment-skip write (f-1) or (f+1) mod 256 to the selected destination and never change Z. When the result is zero, the next slot is a bubble.
- R6: A jump loads PC[10:0] from `ins_lit[10:0]` and PC[12:11] from bits [4:3] of the page latch. The next slot is always a bubble.
- R7: A bubble lasts exactly one cycle, and `busy_o` is high only during it. The instruction offered in that cycle is ignored, and W, Z and the registers keep their values. The PC advances by one in a bubble that follows a skip and holds in a bubble that follows a jump.
- R8: Every accepted instruction other than a jump advances the PC by one, wrapping from 0x1FFF to 0x0000.
- R9: When `ins_valid` is low outside a bubble, the PC, W, Z and the registers are left unchanged.
- R10: When `page_we` is high, the page latch takes `page_wdata` at the clock edge. A jump accepted at that same edge uses the previous latch value.
- R11: While reset is active, the PC, W, Z, the page latch, the bubble state and all 128 registers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ins_valid | input | 1 | An instruction is offered this cycle |
| ins_op | input | 3 | Operation code |
| ins_addr | input | 7 | Register index |
| ins_dst | input | 1 | Destination: 0 = W, 1 = register |
| ins_lit | input | 11 | Immediate: byte in [7:0], or jump target |
| page_we | input | 1 | Page latch write enable |
| page_wdata | input | 8 | Page latch write data |
| pc_o | output | 13 | Program counter |
| w_o | output | 8 | Working register |
| z_o | output | 1 | Zero flag |
| busy_o | output | 1 | Bubble slot; the offered instruction is dropped |

## Verification
Two things can meet in one cycle. A page-latch write can coincide with a jump, and an instruction can be offered in the same slot that a bubble swallows. Directed steps put a page write on the same edge as a jump and then issue a second jump, and the bench expects the old page bits first and the new ones second. Random streams with a high valid rate keep instructions arriving during bubbles, and a bench model predicts PC, W, Z and busy every cycle. Register contents are read back through increment-to-W instructions.

// File: rtl/acc_pkg.sv
package acc_pkg;
   typedef enum logic [2:0] {
      OP_INC  = 3'd0,
      OP_DSKP = 3'd1,
      OP_ISKP = 3'd2,
      OP_ORR  = 3'd3,
      OP_ORL  = 3'd4,
      OP_JMP  = 3'd5,
      OP_NA6  = 3'd6,
      OP_NA7  = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      BUB_NONE = 2'd0,
      BUB_SKIP = 2'd1,
      BUB_JMP  = 2'd2
   } bub_e;
endpackage

// File: rtl/acc_regbank.sv
module acc_regbank #(
   parameter int DW         = 8,
   parameter int AW         = 7,
   parameter bit CLR_ON_RST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata
);
   localparam int DEPTH = 1 << AW;

   if (DW < 1 || AW < 1) begin : g_bad_cfg
      $error("acc_regbank: widths must be positive");
   end

   logic [DW-1:0] mem [DEPTH];

   if (CLR_ON_RST) begin : g_clr
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we) begin
            mem[waddr] <= wdata;
         end
      end
   end else begin : g_noclr
      always_ff @(posedge clk) begin
         if (we) mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int DW = 8
) (
   input  op_e           op,
   input  logic [DW-1:0] f_val,
   input  logic [DW-1:0] w_val,
   input  logic [DW-1:0] lit,
   output logic [DW-1:0] res,
   output logic          zero,
   output logic          z_upd,
   output logic          reg_dst_ok,
   output logic          skip_op
);
   always_comb begin
      res        = w_val;
      z_upd      = 1'b0;
      reg_dst_ok = 1'b0;
      skip_op    = 1'b0;
      unique case (op)
         OP_INC:  begin res = f_val + 1'b1; z_upd = 1'b1; reg_dst_ok = 1'b1; end
         OP_ISKP: begin res = f_val + 1'b1; skip_op = 1'b1; reg_dst_ok = 1'b1; end
         OP_DSKP: begin res = f_val - 1'b1; skip_op = 1'b1; reg_dst_ok = 1'b1; end
         OP_ORR:  begin res = w_val | f_val; z_upd = 1'b1; reg_dst_ok = 1'b1; end
         OP_ORL:  begin res = w_val | lit;   z_upd = 1'b1; end
         default: ;
      endcase
   end

   assign zero = (res == '0);
endmodule

// File: rtl/acc_pcseq.sv
module acc_pcseq #(
   parameter int PCW = 13
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           advance,
   input  logic           load,
   input  logic [PCW-1:0] target,
   output logic [PCW-1:0] pc
);
   logic [PCW-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       pc_q <= '0;
      else if (load)    pc_q <= target;
      else if (advance) pc_q <= pc_q + 1'b1;
   end

   assign pc = pc_q;

   // R8: one step per advance, modulo 2^PCW
   a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |=> (pc_q == PCW'($past(pc_q) + 1'b1)));

   // R6: load wins and takes the target
   a_r6_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (pc_q == $past(target)));
endmodule

// File: rtl/acc_skip_core.sv
module acc_skip_core
   import acc_pkg::*;
#(
   parameter int DW      = 8,
   parameter int AW      = 7,
   parameter int PCW     = 13,
   parameter int IMMW    = 11,
   parameter int PAGE_LO = 3,
   parameter bit RF_CLR  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ins_valid,
   input  logic [2:0]      ins_op,
   input  logic [AW-1:0]   ins_addr,
   input  logic            ins_dst,
   input  logic [IMMW-1:0] ins_lit,
   input  logic            page_we,
   input  logic [DW-1:0]   page_wdata,
   output logic [PCW-1:0]  pc_o,
   output logic [DW-1:0]   w_o,
   output logic            z_o,
   output logic            busy_o
);
   localparam int PGW = PCW - IMMW;

   if (PGW < 1 || PAGE_LO + PGW > DW || IMMW < DW) begin : g_bad_cfg
      $error("acc_skip_core: page field or immediate width out of range");
   end

   op_e           op;
   bub_e          bub_q, bub_d;
   logic          exec, is_jmp, skip_hit;
   logic [DW-1:0] f_val, res, w_q, page_q;
   logic          zero, z_upd, reg_dst_ok, skip_op, z_q;
   logic          rf_we, w_we;

   assign op     = op_e'(ins_op);
   assign exec   = ins_valid && (bub_q == BUB_NONE);
   assign is_jmp = exec && (op == OP_JMP);

   acc_regbank #(.DW(DW), .AW(AW), .CLR_ON_RST(RF_CLR)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .raddr(ins_addr), .rdata(f_val),
      .we(rf_we), .waddr(ins_addr), .wdata(res));

   acc_alu #(.DW(DW)) u_alu (
      .op(op), .f_val(f_val), .w_val(w_q), .lit(ins_lit[DW-1:0]),
      .res(res), .zero(zero), .z_upd(z_upd),
      .reg_dst_ok(reg_dst_ok), .skip_op(skip_op));

   assign rf_we    = exec && reg_dst_ok && ins_dst;
   assign w_we     = exec && ((reg_dst_ok && !ins_dst) || (op == OP_ORL));
   assign skip_hit = exec && skip_op && zero;

   always_comb begin
      bub_d = BUB_NONE;
      if (is_jmp)        bub_d = BUB_JMP;
      else if (skip_hit) bub_d = BUB_SKIP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_q    <= '0;
         z_q    <= 1'b0;
         bub_q  <= BUB_NONE;
         page_q <= '0;
      end else begin
         if (w_we)           w_q <= res;
         if (exec && z_upd)  z_q <= zero;
         bub_q <= bub_d;
         if (page_we)        page_q <= page_wdata;
      end
   end

   acc_pcseq #(.PCW(PCW)) u_pc (
      .clk(clk), .rst_n(rst_n),
      .advance((exec && !is_jmp) || (bub_q == BUB_SKIP)),
      .load(is_jmp),
      .target({page_q[PAGE_LO +: PGW], ins_lit}),
      .pc(pc_o));

   assign w_o    = w_q;
   assign z_o    = z_q;
   assign busy_o = (bub_q != BUB_NONE);

   // R7: a bubble never lasts more than one cycle
   a_r7_bubble_single: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !busy_o);

   // R7: W and Z frozen across a bubble
   a_r7_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ($stable(w_o) && $stable(z_o)));

   // R6: every accepted jump is followed by a bubble
   a_r6_jump_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !busy_o && ins_op == 3'd5) |=> busy_o);

   // R5: skip instructions leave Z alone
   a_r5_skip_keeps_z: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !busy_o && (ins_op == 3'd1 || ins_op == 3'd2)) |=> $stable(z_o));

   // R9: idle slot changes nothing visible
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ins_valid && !busy_o) |=> ($stable(pc_o) && $stable(w_o) && $stable(z_o)));

   // R4: OR with immediate lands in W
   a_r4_orl_w: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !busy_o && ins_op == 3'd4) |=>
         (w_o == ($past(w_o) | $past(ins_lit[DW-1:0]))));
endmodule

// File: tb/tb_acc_skip_core.sv
module tb_acc_skip_core;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ins_valid;
   logic [2:0]  ins_op;
   logic [6:0]  ins_addr;
   logic        ins_dst;
   logic [10:0] ins_lit;
   logic        page_we;
   logic [7:0]  page_wdata;
   logic [12:0] pc_o;
   logic [7:0]  w_o;
   logic        z_o;
   logic        busy_o;

   always #4 clk = ~clk;

   acc_skip_core dut (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
      .ins_addr(ins_addr), .ins_dst(ins_dst), .ins_lit(ins_lit),
      .page_we(page_we), .page_wdata(page_wdata),
      .pc_o(pc_o), .w_o(w_o), .z_o(z_o), .busy_o(busy_o));

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [12:0] m_pc;
   logic [7:0]  m_w, m_page;
   logic        m_z;
   logic [1:0]  m_bub;
   logic [7:0]  m_reg [128];

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [12:0] jmp_tgt(input logic [7:0] pg, input logic [10:0] k);
      return {pg[4:3], k};
   endfunction

   task automatic put(input logic d, input logic [6:0] a, input logic [7:0] r);
      if (d) m_reg[a] = r; else m_w = r;
   endtask

   task automatic step(input logic v, input logic [2:0] op, input logic [6:0] a,
                       input logic d, input logic [10:0] k,
                       input logic pwe, input logic [7:0] pd, input string ftag);
      string tag;
      logic [7:0] r;
      ins_valid = v; ins_op = op; ins_addr = a; ins_dst = d; ins_lit = k;
      page_we = pwe; page_wdata = pd;
      tag = "R9";
      if (m_bub == 2'd1) begin
         m_pc = m_pc + 1'b1; m_bub = 2'd0; tag = "R7";
      end else if (m_bub == 2'd2) begin
         m_bub = 2'd0; tag = "R7";
      end else if (v) begin
         case (op)
            3'd0: begin r = m_reg[a] + 1'b1; put(d, a, r); m_z = (r == 0);
                        m_pc = m_pc + 1'b1; tag = "R2"; end
            3'd1: begin r = m_reg[a] - 1'b1; put(d, a, r);
                        m_pc = m_pc + 1'b1; if (r == 0) m_bub = 2'd1; tag = "R5"; end
            3'd2: begin r = m_reg[a] + 1'b1; put(d, a, r);
                        m_pc = m_pc + 1'b1; if (r == 0) m_bub = 2'd1; tag = "R5"; end
            3'd3: begin r = m_w | m_reg[a]; put(d, a, r); m_z = (r == 0);
                        m_pc = m_pc + 1'b1; tag = "R3"; end
            3'd4: begin m_w = m_w | k[7:0]; m_z = (m_w == 0);
                        m_pc = m_pc + 1'b1; tag = "R4"; end
            3'd5: begin m_pc = jmp_tgt(m_page, k); m_bub = 2'd2; tag = "R6"; end
            default: begin m_pc = m_pc + 1'b1; tag = "R1"; end
         endcase
      end
      if (pwe) m_page = pd;
      if (ftag != "") tag = ftag;
      @(posedge clk);
      @(negedge clk);
      chk(tag, "pc", int'(pc_o), int'(m_pc));
      chk(tag, "w", int'(w_o), int'(m_w));
      chk(tag, "z", int'(z_o), int'(m_z));
      chk(tag, "busy", int'(busy_o), int'(m_bub != 2'd0));
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; ins_valid = 0; ins_op = 0; ins_addr = 0; ins_dst = 0;
      ins_lit = 0; page_we = 0; page_wdata = 0;
      m_pc = 0; m_w = 0; m_z = 0; m_bub = 0; m_page = 0;
      for (int i = 0; i < 128; i++) m_reg[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state at the ports
      chk("R11", "pc", int'(pc_o), 0);
      chk("R11", "w", int'(w_o), 0);
      chk("R11", "z", int'(z_o), 0);
      chk("R11", "busy", int'(busy_o), 0);
      // R11: every register reads zero (increment to W yields 1)
      for (int i = 0; i < 128; i++) step(1, 3'd0, 7'(i), 0, 0, 0, 0, "R11");

      // R2 / R5: wrap 0xFF -> 0x00 on increment-skip gives bubble
      step(1, 3'd1, 7'd10, 1, 0, 0, 0, "R5");          // reg10 = 0xFF
      step(1, 3'd2, 7'd10, 1, 0, 0, 0, "R5");          // -> 0x00, skip
      step(1, 3'd4, 7'd0, 0, 11'h0FF, 0, 0, "R7");     // dropped in bubble
      // decrement of 1 to 0 with result to W
      step(1, 3'd0, 7'd11, 1, 0, 0, 0, "R2");          // reg11 = 1
      step(1, 3'd1, 7'd11, 0, 0, 0, 0, "R5");          // W = 0, skip
      step(0, 3'd0, 7'd0, 0, 0, 0, 0, "R7");           // bubble without valid
      step(1, 3'd4, 7'd0, 0, 11'h000, 0, 0, "R4");     // Z set from zero W
      step(1, 3'd4, 7'd0, 1, 11'h5A0, 0, 0, "R4");     // dst ignored
      step(1, 3'd3, 7'd11, 1, 0, 0, 0, "R3");
      step(0, 3'd2, 7'd11, 1, 0, 0, 0, "R9");
      step(1, 3'd6, 7'd11, 1, 0, 0, 0, "R1");
      // R10: page write alongside jump uses old page, next jump new page
      step(1, 3'd5, 7'd0, 0, 11'h123, 1, 8'h18, "R10");
      step(1, 3'd0, 7'd0, 0, 0, 0, 0, "R7");
      step(1, 3'd5, 7'd0, 0, 11'h7FF, 0, 0, "R10");    // pc = 0x1FFF
      step(1, 3'd7, 7'd0, 0, 0, 0, 0, "R7");
      step(1, 3'd7, 7'd0, 0, 0, 0, 0, "R8");           // wraps to 0
      step(1, 3'd4, 7'd0, 0, 11'h001, 1, 8'h08, "R8");

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [6:0] a;
         a = ($urandom_range(0, 3) == 0) ? 7'(120 + $urandom_range(0, 7))
                                         : 7'($urandom_range(0, 5));
         step($urandom_range(0, 9) != 0, 3'($urandom_range(0, 7)), a,
              1'($urandom_range(0, 1)), 11'($urandom_range(0, 2047)),
              $urandom_range(0, 9) == 0, 8'($urandom_range(0, 255)), "");
      end

      // final readback of every register through W
      step(0, 3'd0, 7'd0, 0, 0, 0, 0, "");
      for (int i = 0; i < 128; i++) step(1, 3'd0, 7'(i), 0, 0, 0, 0, "R2");

      summary();
      $finish;
   end
endmodule